// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns a small set of dedicated external interrupt pins into interrupt requests. Each pin has its own 2-bit sense selection: low level, any change, falling edge, or rising edge. In the three edge modes the pin is first passed through a synchronizer. A history register then compares each new sample with the previous one. A detected edge sets a sticky per-pin flag, which stays set until software pulses that pin's clear strobe. The registered request output is the flag gated by the pin's enable.

Low-level mode stores no flag. The request follows the synchronized pin level, gated by the enable, and stays asserted for as long as the pin is held low. A separate wake output is built from the raw pin with combinational logic only. It can therefore be seen while the I/O clock is stopped, and a sleep controller can use it to restart the clock.

A clock-running input marks whether the I/O clock is present. While it is low, the edge machinery is frozen, so transitions during that time are never recognized as edges. After the clock resumes, edge detection is held off until the synchronizer has refilled. A low pulse that ends before the clock returns raises wake but never produces a request.

Top module: `eint_sense_unit`

## Requirements
- R1: While reset is asserted, and after it is released with all enables low, `irq_o` is all zeros and `wake_o` is 0.
- R2: The sense field of pin k is `sense_i[2k+1:2k]`, encoded as 00 low level, 01 any change, 10 falling edge, 11 rising edge. In rising mode, a 0-to-1 pin change applied between clock edges sets the pin's `irq_o` bit after the fourth following rising clock edge. A 1-to-0 change in this mode raises no request.
- R3: In falling mode, a 1-to-0 change raises the request with the same four-edge latency, and a 0-to-1 change raises none.
- R4: In any-change mode, both directions of pin change raise the request.
- R5: An edge request is sticky. It drops one edge after the edge that sampled a `flag_clr_i` pulse. When an edge is detected on the same edge as a clear, the set wins.
- R6: An edge is recorded in the flag even while the enable is low. `irq_o` follows `enable_i` on the next clock edge.
- R7: In low-level mode, the request rises after the third edge following the pin going low. It stays high for as long as the pin is low, and it falls three edges after the pin returns high.
- R8: While `clk_run_i` is low, synchronizer, history and flags hold. A transition that happens while the clock is stopped is never reported as an edge. Edge detection is suppressed for the resume edge and the following SYNC_STAGES edges.
- R9: `wake_o` is high, without any clock edge, exactly when some pin is enabled, is in low-level mode and is low. This holds whatever `clk_run_i` is.
- R10: If a low level disappears before the clock resumes, wake is seen but no request is raised. A level still held low at resume raises the request after the third edge.
- R11: A change of a pin's sense field clears its flag and suppresses a pending edge on that pin, so no false edge is reported.
- R12: Pins are independent. Activity on one pin never changes another pin's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_run_i | input | 1 | High while the I/O clock is running |
| pin_i | input | N_PINS | External interrupt pins |
| sense_i | input | 2*N_PINS | Sense selection, 2 bits per pin |
| enable_i | input | N_PINS | Per-pin request enable |
| flag_clr_i | input | N_PINS | Per-pin flag clear strobe |
| irq_o | output | N_PINS | Registered interrupt requests |
| wake_o | output | 1 | Clock-independent wake request |

## Verification
Each edge mode receives both pin directions. This separates rising, falling and any-change decoding, and sampling one edge early and at the expected edge pins down the four-edge latency. Level mode is held low for many cycles and then released, which separates a level follower from a pulse or latch. A clear strobe that coincides with a new edge shows which of set and clear has priority. A mode switch with an edge already in the synchronizer, and toggles while the clock is stopped, separate correct history reloading from false-edge reporting. Short and held low pulses during a stop tell the raw wake path apart from the synchronized request.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  // The chain only advances while the I/O clock is marked running; idle level is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '1;
    end else if (adv) begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eint_settle.sv
module eint_settle #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic suppress
);
  localparam int CW = $clog2(STAGES + 1);

  logic          run_q;
  logic [CW-1:0] cnt;
  logic          resume;

  assign resume   = run & ~run_q;
  assign suppress = resume | (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt   <= '0;
    end else begin
      run_q <= run;
      if (resume)                cnt <= CW'(STAGES);
      else if (run && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  AST_SETTLE_ON_RESUME: assert property (@(posedge clk) disable iff (rst)
    (run && !run_q) |=> (cnt != '0)); // R8
endmodule

// File: rtl/eint_wake.sv
module eint_wake
  import eint_pkg::*;
#(
  parameter int N_PINS = 2
) (
  input  logic [N_PINS-1:0]   pin,
  input  logic [2*N_PINS-1:0] sense,
  input  logic [N_PINS-1:0]   en,
  output logic                wake
);
  logic [N_PINS-1:0] lvl_hit;

  for (genvar g = 0; g < N_PINS; g++) begin : g_lvl
    assign lvl_hit[g] = en[g] & ~pin[g] & (sense_e'(sense[2*g+1:2*g]) == SENSE_LOW);
  end

  assign wake = |lvl_hit;
endmodule

// File: rtl/eint_chan.sv
module eint_chan
  import eint_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       suppress,
  input  logic       s_in,
  input  logic [1:0] sense,
  input  logic       en,
  input  logic       clr,
  output logic       irq_o
);
  sense_e mode, mode_q;
  logic   hist_q, flag_q, irq_q;
  logic   mode_chg, raw_edge, edge_evt;

  assign mode     = sense_e'(sense);
  assign mode_chg = (mode != mode_q);

  always_comb begin
    unique case (mode)
      SENSE_RISE: raw_edge = s_in & ~hist_q;
      SENSE_FALL: raw_edge = ~s_in & hist_q;
      SENSE_ANY:  raw_edge = s_in ^ hist_q;
      default:    raw_edge = 1'b0;
    endcase
  end

  assign edge_evt = raw_edge & ~suppress & ~mode_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SENSE_LOW;
      hist_q <= 1'b1;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (run) begin
      mode_q <= mode;
      hist_q <= s_in;
      if (mode_chg)      flag_q <= 1'b0;
      else if (edge_evt) flag_q <= 1'b1;
      else if (clr)      flag_q <= 1'b0;
      irq_q <= en & ((mode == SENSE_LOW) ? ~s_in : flag_q);
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (run && !en) |=> !irq_q); // R6
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (run && clr && !raw_edge) |=> !flag_q); // R5
  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(flag_q) && $stable(hist_q))); // R8
  AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (run && mode == SENSE_LOW) |=> !flag_q); // R7
  AST_SUPPRESS_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (run && (suppress || mode_chg) && !flag_q) |=> !flag_q); // R11
endmodule

// File: rtl/eint_sense_unit.sv
module eint_sense_unit #(
  parameter int N_PINS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_run_i,
  input  logic [N_PINS-1:0]   pin_i,
  input  logic [2*N_PINS-1:0] sense_i,
  input  logic [N_PINS-1:0]   enable_i,
  input  logic [N_PINS-1:0]   flag_clr_i,
  output logic [N_PINS-1:0]   irq_o,
  output logic                wake_o
);
  logic [N_PINS-1:0] pin_s;
  logic              suppress;

  eint_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .adv(clk_run_i), .d(pin_i), .q(pin_s)
  );

  eint_settle #(.STAGES(SYNC_STAGES)) u_settle (
    .clk(clk), .rst(rst), .run(clk_run_i), .suppress(suppress)
  );

  eint_wake #(.N_PINS(N_PINS)) u_wake (
    .pin(pin_i), .sense(sense_i), .en(enable_i), .wake(wake_o)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_chan
    eint_chan u_chan (
      .clk(clk), .rst(rst), .run(clk_run_i), .suppress(suppress),
      .s_in(pin_s[g]), .sense(sense_i[2*g+1:2*g]), .en(enable_i[g]),
      .clr(flag_clr_i[g]), .irq_o(irq_o[g])
    );
  end

  AST_WAKE_IS_LOW_LEVEL: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (pin_i != '1)); // R9
endmodule

// File: tb/tb_eint_sense_unit.sv
module tb_eint_sense_unit;
  localparam int N = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           clk_run_i = 1'b1;
  logic [N-1:0]   pin_i = '1;
  logic [2*N-1:0] sense_i = 4'b1111;
  logic [N-1:0]   enable_i = '0;
  logic [N-1:0]   flag_clr_i = '0;
  logic [N-1:0]   irq_o;
  logic           wake_o;

  eint_sense_unit #(.N_PINS(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .clk_run_i(clk_run_i), .pin_i(pin_i), .sense_i(sense_i),
    .enable_i(enable_i), .flag_clr_i(flag_clr_i), .irq_o(irq_o), .wake_o(wake_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [N-1:0] irq;
    logic         wake;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // Monitor: compare one queued expectation per falling clock edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_run++;
      if (irq_o !== e.irq || wake_o !== e.wake) begin
        n_fail++;
        $display("FAIL %s: irq=%b wake=%b expected irq=%b wake=%b",
                 e.tag, irq_o, wake_o, e.irq, e.wake);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(logic [N-1:0] irq, logic wake, string tag);
    exp_t e;
    e.irq = irq; e.wake = wake; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic clear_flags(logic [N-1:0] m);
    flag_clr_i = m;
    tick(1);
    flag_clr_i = '0;
    tick(1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_out(2'b00, 1'b0, "R1 during reset");
    rst = 0;
    tick(5);
    expect_out(2'b00, 1'b0, "R1 after reset");
    enable_i = 2'b11;
    tick(1);

    // R2 rising mode
    pin_i[0] = 0; tick(6);
    expect_out(2'b00, 1'b0, "R2 falling change ignored in rise mode");
    pin_i[0] = 1; tick(3);
    expect_out(2'b00, 1'b0, "R2 not before fourth edge");
    tick(1);
    expect_out(2'b01, 1'b0, "R2 rise request");

    // R5 sticky and clear
    pin_i[0] = 0; tick(6);
    expect_out(2'b01, 1'b0, "R5 request sticky");
    flag_clr_i = 2'b01; tick(1); flag_clr_i = 0; tick(1);
    expect_out(2'b00, 1'b0, "R5 clear drops request");
    pin_i[0] = 1; tick(2);
    flag_clr_i = 2'b01; tick(1); flag_clr_i = 0; tick(1);
    expect_out(2'b01, 1'b0, "R5 set wins over clear");
    clear_flags(2'b01);

    // R3 falling mode
    sense_i[1:0] = 2'b10; tick(3);
    pin_i[0] = 0; tick(4);
    expect_out(2'b01, 1'b0, "R3 fall request");
    clear_flags(2'b01);
    pin_i[0] = 1; tick(6);
    expect_out(2'b00, 1'b0, "R3 rising change ignored");

    // R4 any change
    sense_i[1:0] = 2'b01; tick(3);
    pin_i[0] = 0; tick(4);
    expect_out(2'b01, 1'b0, "R4 any change falling");
    clear_flags(2'b01);
    expect_out(2'b00, 1'b0, "R4 cleared");
    pin_i[0] = 1; tick(4);
    expect_out(2'b01, 1'b0, "R4 any change rising");
    clear_flags(2'b01);

    // R6 enable gating
    enable_i = 2'b10;
    pin_i[0] = 0; tick(6);
    expect_out(2'b00, 1'b0, "R6 disabled no request");
    enable_i = 2'b11; tick(1);
    expect_out(2'b01, 1'b0, "R6 flag kept, request after enable");
    clear_flags(2'b01);
    pin_i[0] = 1; tick(6);
    clear_flags(2'b01);

    // R7 / R9 level mode
    sense_i[1:0] = 2'b00; tick(3);
    expect_out(2'b00, 1'b0, "R7 level mode pin high");
    pin_i[0] = 0; #1;
    expect_out(2'b00, 1'b1, "R9 wake without clock edge");
    pin_i[0] = 1; tick(4);
    pin_i[0] = 0; tick(2);
    expect_out(2'b00, 1'b1, "R7 level latency");
    tick(1);
    expect_out(2'b01, 1'b1, "R7 level request");
    tick(10);
    expect_out(2'b01, 1'b1, "R7 level request held");
    pin_i[0] = 1; tick(2);
    expect_out(2'b01, 1'b0, "R7 release latency");
    tick(1);
    expect_out(2'b00, 1'b0, "R7 released");

    // R8 clock stopped
    sense_i[1:0] = 2'b11; tick(3);
    pin_i[0] = 0; tick(5);
    clk_run_i = 0; tick(2);
    pin_i[0] = 1; tick(5);
    clk_run_i = 1; tick(8);
    expect_out(2'b00, 1'b0, "R8 edge during stop not seen");
    pin_i[0] = 0; tick(5);
    pin_i[0] = 1; tick(4);
    expect_out(2'b01, 1'b0, "R8 edge seen after resume");
    clear_flags(2'b01);

    // R10 short and held low during stop
    sense_i[1:0] = 2'b00; tick(3);
    clk_run_i = 0; tick(1);
    pin_i[0] = 0; #1;
    expect_out(2'b00, 1'b1, "R9 wake while clock stopped");
    tick(3);
    expect_out(2'b00, 1'b1, "R10 no request while stopped");
    pin_i[0] = 1; #1;
    expect_out(2'b00, 1'b0, "R10 wake drops with pin");
    clk_run_i = 1; tick(6);
    expect_out(2'b00, 1'b0, "R10 short low gives no request");
    clk_run_i = 0; tick(1);
    pin_i[0] = 0; tick(2);
    clk_run_i = 1; tick(2);
    expect_out(2'b00, 1'b1, "R10 refill after resume");
    tick(1);
    expect_out(2'b01, 1'b1, "R10 held low gives request");
    pin_i[0] = 1; tick(4);

    // R11 mode change
    sense_i[1:0] = 2'b11; tick(3);
    pin_i[0] = 0; tick(2);
    sense_i[1:0] = 2'b10; tick(6);
    expect_out(2'b00, 1'b0, "R11 pending edge suppressed");
    pin_i[0] = 1; tick(3);
    pin_i[0] = 0; tick(4);
    expect_out(2'b01, 1'b0, "R11 fall seen in new mode");
    sense_i[1:0] = 2'b11; tick(2);
    expect_out(2'b00, 1'b0, "R11 mode change clears flag");

    // R12 independence
    pin_i[1] = 0; tick(3);
    pin_i[1] = 1; tick(4);
    expect_out(2'b10, 1'b0, "R12 pin1 request only");
    clear_flags(2'b10);
    expect_out(2'b00, 1'b0, "R12 pin1 cleared");

    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule